// File: doc/BRIEF.md
# Paged OSD Register and Display-RAM Access Decoder

This block sits between a processor's byte-wide data bus and the storage of an on-screen display controller. The processor sees only a 64-location window at addresses 00h to 3Fh. A bank register chooses what appears there. When the bank holds the display page value, the window is split in two. The six highest locations hold the display's positioning, spacing and background registers. The lower 58 locations show one slice of the 168-word display RAM. A two-bit slice field in the global enable register picks that slice.

The global enable register, the polarity select register and the bank register sit at fixed addresses outside the window. They can be reached at any time. An access-enable bit in the global enable register opens the windowed registers and the RAM to the processor. While that bit is clear, windowed writes are dropped and windowed reads return zero.

Requests arrive on a valid/ready channel. A read returns its data on a valid/ready response channel one cycle after it is accepted. A write is complete when it is accepted and produces no response. The response register holds one entry. While it is full and the consumer is stalling (`rsp_ready` low), `req_ready` is low and no request is taken. A request held on `req_valid` must keep its fields stable until it is accepted.

Top module: `osd_paged_access`

## Requirements
- R1: After reset, every register (bank, global enable, polarity, the six windowed registers) and every RAM word is 00h, so every read returns 00h.
- R2: Address E8h is the bank register, EAh is global enable and EBh is polarity select. All three read back the last value written, whatever the bank and global enable hold.
- R3: Window addresses 00h–3Fh reach display storage only while the bank register equals 20h. Otherwise, reads there return 00h and writes there change nothing.
- R4: With the window open, addresses 3Ah, 3Bh, 3Ch, 3Dh, 3Eh and 3Fh are, in that order, vertical start, horizontal start, vertical space 0, vertical space 1, horizontal space and background control. Each reads back what was written.
- R5: With the window open, address a in 00h–39h reaches RAM word slice*58 + a, where slice is global enable bits [1:0].
- R6: RAM word numbers 168 and above do not exist. These are offsets 34h–39h of slice 2 and all of slice 3. Reads there return 00h and writes there change no existing word.
- R7: Global enable bit 6 is the access enable. While it is 0, window writes are dropped and window reads return 00h, even with the bank at 20h.
- R8: Addresses 40h–E7h, E9h and ECh–FFh map to nothing. Reads return 00h and writes have no effect.
- R9: `req_ready` equals `!rsp_valid || rsp_ready`. An accepted read raises `rsp_valid` on the next cycle. `rsp_valid` and `rsp_rdata` then hold until `rsp_ready` is seen. An accepted write raises no response.
- R10: A read returns the effect of every write accepted before it, including a write in the immediately preceding accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW (8) | Processor data address |
| req_wdata | input | DW (8) | Write data |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Consumer takes read data |
| rsp_rdata | output | DW (8) | Read data |

## Verification
The bench uses the default parameters: an 8-bit bus, a 64-location window, six windowed registers, 168 RAM words and a two-bit slice field. This makes the RAM slice 58 words wide and leaves the last slice only partly backed. These values bring within reach the word-167/168 edge in slice 2 and the fully empty slice 3, next to the register-to-RAM edge at window offset 3Ah. Random traffic changes the bank and the access bit often. Locked and unpaged accesses therefore mix with legal ones, and a stalled response is driven directly.

// File: rtl/osd_page_pkg.sv
package osd_page_pkg;
  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_BANK,
    TGT_GE,
    TGT_PSR,
    TGT_PREG,
    TGT_RAM
  } tgt_e;
endpackage

// File: rtl/osd_addr_decode.sv
module osd_addr_decode
  import osd_page_pkg::*;
#(
  parameter int AW         = 8,
  parameter int WIN_SIZE   = 64,
  parameter int NUM_PREG   = 6,
  parameter int RAM_WORDS  = 168,
  parameter int SLICE_BITS = 2,
  parameter int BANK_ADDR  = 'hE8,
  parameter int GE_ADDR    = 'hEA,
  parameter int PSR_ADDR   = 'hEB,
  localparam int SLOT      = WIN_SIZE - NUM_PREG,
  localparam int PIW       = (NUM_PREG > 1) ? $clog2(NUM_PREG) : 1,
  localparam int RIW       = $clog2(RAM_WORDS)
) (
  input  logic [AW-1:0]         addr,
  input  logic                  page_sel,
  input  logic                  acc_en,
  input  logic [SLICE_BITS-1:0] slice,
  output tgt_e                  tgt,
  output logic [PIW-1:0]        preg_idx,
  output logic [RIW-1:0]        ram_idx
);
  logic [31:0] off32;
  logic [31:0] word32;
  logic        in_win;

  always_comb begin
    off32    = 32'(addr);
    word32   = 32'(slice) * 32'(SLOT) + off32;
    in_win   = off32 < 32'(WIN_SIZE);
    tgt      = TGT_NONE;
    preg_idx = '0;
    ram_idx  = '0;
    if (addr == AW'(BANK_ADDR)) begin
      tgt = TGT_BANK;
    end else if (addr == AW'(GE_ADDR)) begin
      tgt = TGT_GE;
    end else if (addr == AW'(PSR_ADDR)) begin
      tgt = TGT_PSR;
    end else if (in_win && page_sel && acc_en) begin
      if (off32 >= 32'(SLOT)) begin
        tgt      = TGT_PREG;
        preg_idx = PIW'(off32 - 32'(SLOT));
      end else if (word32 < 32'(RAM_WORDS)) begin
        tgt     = TGT_RAM;
        ram_idx = RIW'(word32);
      end
    end
  end
endmodule

// File: rtl/osd_reg_file.sv
module osd_reg_file
  import osd_page_pkg::*;
#(
  parameter int DW         = 8,
  parameter int NUM_PREG   = 6,
  parameter int SLICE_BITS = 2,
  parameter int ACC_BIT    = 6,
  parameter int OSD_PAGE   = 'h20,
  localparam int PIW       = (NUM_PREG > 1) ? $clog2(NUM_PREG) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  tgt_e                  tgt,
  input  logic [PIW-1:0]        preg_idx,
  input  logic [DW-1:0]         wdata,
  output logic                  page_sel,
  output logic                  acc_en,
  output logic [SLICE_BITS-1:0] slice,
  output logic [DW-1:0]         rdata
);
  logic [DW-1:0] bank_q;
  logic [DW-1:0] ge_q;
  logic [DW-1:0] psr_q;
  logic [DW-1:0] preg_q [NUM_PREG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_q <= '0;
      ge_q   <= '0;
      psr_q  <= '0;
    end else if (wr_en) begin
      if (tgt == TGT_BANK) bank_q <= wdata;
      if (tgt == TGT_GE)   ge_q   <= wdata;
      if (tgt == TGT_PSR)  psr_q  <= wdata;
    end
  end

  for (genvar g = 0; g < NUM_PREG; g++) begin : g_preg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        preg_q[g] <= '0;
      end else if (wr_en && tgt == TGT_PREG && preg_idx == PIW'(g)) begin
        preg_q[g] <= wdata;
      end
    end
  end

  always_comb begin
    unique case (tgt)
      TGT_BANK: rdata = bank_q;
      TGT_GE:   rdata = ge_q;
      TGT_PSR:  rdata = psr_q;
      TGT_PREG: rdata = preg_q[preg_idx];
      default:  rdata = '0;
    endcase
  end

  assign page_sel = (bank_q == DW'(OSD_PAGE));
  assign acc_en   = ge_q[ACC_BIT];
  assign slice    = ge_q[SLICE_BITS-1:0];
endmodule

// File: rtl/osd_disp_ram.sv
module osd_disp_ram #(
  parameter int DW        = 8,
  parameter int RAM_WORDS = 168,
  localparam int RIW      = $clog2(RAM_WORDS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [RIW-1:0] idx,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  rdata
);
  logic [DW-1:0] mem_q [RAM_WORDS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < RAM_WORDS; i++) mem_q[i] <= '0;
    end else if (wr_en) begin
      mem_q[idx] <= wdata;
    end
  end

  assign rdata = mem_q[idx];
endmodule

// File: rtl/osd_paged_access.sv
module osd_paged_access
  import osd_page_pkg::*;
#(
  parameter int AW         = 8,
  parameter int DW         = 8,
  parameter int WIN_SIZE   = 64,
  parameter int NUM_PREG   = 6,
  parameter int RAM_WORDS  = 168,
  parameter int SLICE_BITS = 2,
  parameter int ACC_BIT    = 6,
  parameter int OSD_PAGE   = 'h20,
  parameter int BANK_ADDR  = 'hE8,
  parameter int GE_ADDR    = 'hEA,
  parameter int PSR_ADDR   = 'hEB
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_rdata
);
  localparam int PIW = (NUM_PREG > 1) ? $clog2(NUM_PREG) : 1;
  localparam int RIW = $clog2(RAM_WORDS);

  tgt_e                  tgt;
  logic [PIW-1:0]        preg_idx;
  logic [RIW-1:0]        ram_idx;
  logic                  page_sel;
  logic                  acc_en;
  logic [SLICE_BITS-1:0] slice;
  logic [DW-1:0]         reg_rdata;
  logic [DW-1:0]         ram_rdata;
  logic [DW-1:0]         rd_mux;
  logic                  accept;
  logic                  wr_en;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign wr_en     = accept && req_write;

  osd_addr_decode #(
    .AW(AW), .WIN_SIZE(WIN_SIZE), .NUM_PREG(NUM_PREG), .RAM_WORDS(RAM_WORDS),
    .SLICE_BITS(SLICE_BITS), .BANK_ADDR(BANK_ADDR), .GE_ADDR(GE_ADDR),
    .PSR_ADDR(PSR_ADDR)
  ) u_decode (
    .addr(req_addr), .page_sel(page_sel), .acc_en(acc_en), .slice(slice),
    .tgt(tgt), .preg_idx(preg_idx), .ram_idx(ram_idx)
  );

  osd_reg_file #(
    .DW(DW), .NUM_PREG(NUM_PREG), .SLICE_BITS(SLICE_BITS),
    .ACC_BIT(ACC_BIT), .OSD_PAGE(OSD_PAGE)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .tgt(tgt), .preg_idx(preg_idx),
    .wdata(req_wdata), .page_sel(page_sel), .acc_en(acc_en), .slice(slice),
    .rdata(reg_rdata)
  );

  osd_disp_ram #(
    .DW(DW), .RAM_WORDS(RAM_WORDS)
  ) u_ram (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en && tgt == TGT_RAM),
    .idx(ram_idx), .wdata(req_wdata), .rdata(ram_rdata)
  );

  always_comb begin
    unique case (tgt)
      TGT_RAM:  rd_mux = ram_rdata;
      TGT_NONE: rd_mux = '0;
      default:  rd_mux = reg_rdata;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (accept && !req_write) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_mux;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/osd_access_chk.sv
module osd_access_chk #(
  parameter int AW         = 8,
  parameter int DW         = 8,
  parameter int WIN_SIZE   = 64,
  parameter int NUM_PREG   = 6,
  parameter int RAM_WORDS  = 168,
  parameter int SLICE_BITS = 2,
  parameter int BANK_ADDR  = 'hE8,
  parameter int GE_ADDR    = 'hEA,
  parameter int PSR_ADDR   = 'hEB
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  req_valid,
  input logic                  req_ready,
  input logic                  req_write,
  input logic [AW-1:0]         req_addr,
  input logic                  rsp_valid,
  input logic                  rsp_ready,
  input logic [DW-1:0]         rsp_rdata,
  input logic                  page_sel,
  input logic                  acc_en,
  input logic [SLICE_BITS-1:0] slice
);
  localparam int SLOT = WIN_SIZE - NUM_PREG;

  logic rd_acc;
  logic in_win;
  logic special;
  logic beyond;

  assign rd_acc  = req_valid && req_ready && !req_write;
  assign in_win  = 32'(req_addr) < 32'(WIN_SIZE);
  assign special = req_addr == AW'(BANK_ADDR) || req_addr == AW'(GE_ADDR)
                || req_addr == AW'(PSR_ADDR);
  assign beyond  = 32'(req_addr) < 32'(SLOT)
                && (32'(slice) * 32'(SLOT) + 32'(req_addr)) >= 32'(RAM_WORDS);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));

  // R9
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);

  // R9
  read_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> rsp_valid);

  // R9
  write_norsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_write |=> !rsp_valid);

  // R3
  closed_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc && in_win && !page_sel |=> rsp_rdata == '0);

  // R7
  locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc && in_win && page_sel && !acc_en |=> rsp_rdata == '0);

  // R6
  beyond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc && page_sel && acc_en && beyond |=> rsp_rdata == '0);

  // R8
  unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc && !in_win && !special |=> rsp_rdata == '0);
endmodule

bind osd_paged_access osd_access_chk #(
  .AW(AW), .DW(DW), .WIN_SIZE(WIN_SIZE), .NUM_PREG(NUM_PREG),
  .RAM_WORDS(RAM_WORDS), .SLICE_BITS(SLICE_BITS), .BANK_ADDR(BANK_ADDR),
  .GE_ADDR(GE_ADDR), .PSR_ADDR(PSR_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .page_sel(page_sel),
  .acc_en(acc_en), .slice(slice)
);

// File: tb/test_osd_paged_access.sv
module test_osd_paged_access;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic       req_write = 1'b0;
  logic [7:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic       rsp_valid;
  logic       rsp_ready = 1'b1;
  logic [7:0] rsp_rdata;

  int n_checks = 0;
  int n_fails  = 0;

  logic [7:0] m_bank, m_ge, m_psr;
  logic [7:0] m_preg [6];
  logic [7:0] m_ram  [168];

  always #4 clk = ~clk;

  osd_paged_access i_osd_paged_access (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata)
  );

  task automatic check(input string tag, input bit ok, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic bit win_open();
    return m_bank == 8'h20 && m_ge[6];
  endfunction

  function automatic int ram_word(input logic [7:0] a);
    return int'(m_ge[1:0]) * 58 + int'(a);
  endfunction

  function automatic logic [7:0] exp_read(input logic [7:0] a);
    if (a == 8'hE8) return m_bank;
    if (a == 8'hEA) return m_ge;
    if (a == 8'hEB) return m_psr;
    if (a < 8'h40 && win_open()) begin
      if (a >= 8'h3A) return m_preg[a - 8'h3A];
      if (ram_word(a) < 168) return m_ram[ram_word(a)];
    end
    return 8'h00;
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    if (a == 8'hE8 || a == 8'hEA || a == 8'hEB) return "R2";
    if (a >= 8'h40) return "R8";
    if (m_bank != 8'h20) return "R3";
    if (!m_ge[6]) return "R7";
    if (a >= 8'h3A) return "R4";
    if (ram_word(a) >= 168) return "R6";
    return "R5";
  endfunction

  task automatic mdl_write(input logic [7:0] a, input logic [7:0] d);
    if (a == 8'hE8) m_bank = d;
    else if (a == 8'hEA) m_ge = d;
    else if (a == 8'hEB) m_psr = d;
    else if (a < 8'h40 && win_open()) begin
      if (a >= 8'h3A) m_preg[a - 8'h3A] = d;
      else if (ram_word(a) < 168) m_ram[ram_word(a)] = d;
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    mdl_write(a, d);
  endtask

  task automatic do_read(input logic [7:0] a, input string tag);
    logic [7:0] e;
    e = exp_read(a);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " rsp_valid"}, rsp_valid === 1'b1, int'(rsp_valid), 1);
    check(tag, rsp_rdata === e, int'(rsp_rdata), int'(e));
  endtask

  initial begin
    #(8 * 200000);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    m_bank = 0; m_ge = 0; m_psr = 0;
    for (int i = 0; i < 6; i++) m_preg[i] = 0;
    for (int i = 0; i < 168; i++) m_ram[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 rsp_valid", rsp_valid === 1'b0, int'(rsp_valid), 0);
    check("R9 req_ready", req_ready === 1'b1, int'(req_ready), 1);
    do_read(8'hE8, "R1"); do_read(8'hEA, "R1"); do_read(8'hEB, "R1");
    do_read(8'h3F, "R1");

    do_write(8'hE8, 8'h20);
    do_write(8'hEA, 8'h40);
    do_read(8'h00, "R1");
    do_write(8'h00, 8'hA5);
    do_read(8'h00, "R10");
    for (int i = 0; i < 6; i++) do_write(8'(8'h3A + i), 8'(8'h10 + i));
    for (int i = 0; i < 6; i++) do_read(8'(8'h3A + i), "R4");
    do_write(8'h39, 8'hC3);
    do_read(8'h39, "R5");

    do_write(8'hEA, 8'h41);
    do_read(8'h00, "R5");
    do_write(8'h00, 8'h5A);
    do_write(8'hEA, 8'h40);
    do_read(8'h00, "R5");
    do_write(8'hEA, 8'h41);
    do_read(8'h00, "R5");

    do_write(8'hEA, 8'h42);
    do_write(8'h33, 8'h66);
    do_read(8'h33, "R6 word 167");
    do_write(8'h34, 8'h77);
    do_read(8'h34, "R6 word 168");
    do_write(8'hEA, 8'h43);
    do_write(8'h00, 8'h88);
    do_read(8'h00, "R6 slice 3");
    do_write(8'hEA, 8'h40);
    do_read(8'h00, "R6 slice 0 intact");

    do_write(8'hEA, 8'h00);
    do_read(8'h3A, "R7");
    do_write(8'h3A, 8'hFF);
    do_write(8'h00, 8'hFF);
    do_write(8'hEA, 8'h40);
    do_read(8'h3A, "R7");
    do_read(8'h00, "R7");

    do_write(8'hE8, 8'h21);
    do_read(8'h00, "R3");
    do_write(8'h00, 8'h11);
    do_write(8'hEB, 8'h3C);
    do_read(8'hEB, "R2");
    do_read(8'hEA, "R2");
    do_write(8'hE8, 8'h20);
    do_read(8'h00, "R3");

    do_write(8'h80, 8'h99);
    do_read(8'h80, "R8");
    do_write(8'hE9, 8'h99);
    do_read(8'hE9, "R8");
    do_read(8'h40, "R8");
    do_read(8'h3A, "R8 intact");

    // R9 back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 8'h3B;
    @(negedge clk);
    req_write = 1'b1; req_wdata = 8'h99;
    check("R9 rsp_valid", rsp_valid === 1'b1, int'(rsp_valid), 1);
    check("R9 stall ready", req_ready === 1'b0, int'(req_ready), 0);
    check("R9 data", rsp_rdata === m_preg[1], int'(rsp_rdata), int'(m_preg[1]));
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R9 hold valid", rsp_valid === 1'b1, int'(rsp_valid), 1);
      check("R9 hold data", rsp_rdata === m_preg[1], int'(rsp_rdata), int'(m_preg[1]));
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    mdl_write(8'h3B, 8'h99);
    check("R9 drained", rsp_valid === 1'b0, int'(rsp_valid), 0);
    do_read(8'h3B, "R10");

    for (int n = 0; n < 4000; n++) begin
      logic [7:0] a;
      int sel;
      sel = int'($urandom % 16);
      if (sel < 9)       a = 8'($urandom % 64);
      else if (sel < 10) a = 8'h3A + 8'($urandom % 6);
      else if (sel < 12) a = 8'hEA;
      else if (sel < 13) a = 8'hE8;
      else if (sel < 14) a = 8'hEB;
      else               a = 8'($urandom);
      if ($urandom % 2 == 0) begin
        logic [7:0] d;
        d = 8'($urandom);
        if (a == 8'hE8) d = ($urandom % 4 != 0) ? 8'h20 : d;
        if (a == 8'hEA && $urandom % 4 != 0) d[6] = 1'b1;
        do_write(a, d);
      end else begin
        do_read(a, tag_of(a));
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'h5eed_0d5a);
  end
endmodule